// File: doc/BRIEF.md
# Set-Associative Cache Hit/Miss Profiler

This block models the tag side of a set-associative cache and classifies every memory reference it receives. A reference carries a two-bit operation code and a 64-bit byte address. The block reports whether the reference found its block resident (hit), placed it in a free line (miss), or had to displace a resident block (miss with eviction). It also keeps three running totals. No data is held. Each line stores only a tag, a valid bit and a recency stamp. There is no backing store, no write-back and no coherence. The block exists to measure how a given reference stream behaves on a cache geometry that is fixed when the design is built.

The geometry is set by three parameters: the number of block-offset bits, the number of set-index bits and the number of ways. Replacement is least-recently-used. Each line remembers the sequence number of the reference that last touched it, and the victim is the line with the smallest number. A read-modify-write reference is treated as a lookup followed by a store to the same block, and that store is always a hit. References arrive on a valid/ready stream, and each one yields one result two clock edges after it is accepted.

Top module: `cache_profiler`

## Requirements
- R1: An address is split into three fields. The low OFF_BITS bits are the block offset, which is ignored. The next SET_BITS bits select the set. All higher bits up to bit 63 form the tag. Two addresses that differ only in the offset hit the same line.
- R2: An instruction fetch (inOp = 0) yields result code 0 (skip). It leaves every line and every counter unchanged.
- R3: A load (inOp = 1) or store (inOp = 2) whose tag matches a valid line in its set yields code 1 (hit). It adds one to hitCount and refreshes that line's recency stamp.
- R4: A load or store that misses in a set that still has an invalid line yields code 2 (miss). It fills the lowest-numbered invalid way and adds one to missCount only.
- R5: A load or store that misses in a full set yields code 3 (miss with eviction). It replaces the line with the smallest recency stamp and adds one to both missCount and evictCount. Stamps come from a reference counter that advances on every accepted reference, fetches included. Ties go to the lowest way.
- R6: A modify (inOp = 3) is classified like a load, giving code 1, 2 or 3, and raises outStoreHit. hitCount gains one more for the store half, so it rises by 2 on a modify hit and by 1 on a modify miss.
- R7: A reference accepted at a rising edge produces outValid, together with its code and the updated counters, right after the next rising edge. References may be sent back to back, and each one sees every state change made by the reference before it.
- R8: A synchronous reset invalidates every line and clears all counters and the stamp counter. Afterwards every reference misses until its block is loaded again.
- R9: The counters saturate at 2^CNT_W-1 and never wrap, including when a modify adds 2.
- R10: inReady is high whenever reset is low, and every reference offered while it is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Reference offered |
| inReady | output | 1 | Reference can be accepted |
| inOp | input | 2 | 0 fetch, 1 load, 2 store, 3 modify |
| inAddr | input | 64 | Byte address of the reference |
| outValid | output | 1 | Result valid this cycle |
| outCode | output | 2 | 0 skip, 1 hit, 2 miss, 3 miss with eviction |
| outStoreHit | output | 1 | Extra store hit of a modify reference |
| hitCount | output | CNT_W | Saturating hit total |
| missCount | output | CNT_W | Saturating miss total |
| evictCount | output | CNT_W | Saturating eviction total |

## Verification
The assertions check several properties on every cycle:
- the counters never step backwards;
- the eviction total never exceeds the miss total;
- a skip result leaves all three totals frozen;
- hit and miss results move exactly the totals they should;
- the store-hit flag appears only on a non-skip result;
- every result traces back to a reference accepted two edges earlier.

Some behaviours can only be shown by the bench scenarios, because they depend on which line is stored where. These are:
- the choice of way on a fill;
- the least-recently-used victim after a refresh or an intervening fetch;
- the full width of the tag compare;
- the loss of all lines at reset;
- the clamp of a modify at the top of the counter range.

// File: rtl/cache_prof_pkg.sv
package cache_prof_pkg;

  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_MODIFY = 2'd3
  } refOp_e;

  typedef enum logic [1:0] {
    RES_SKIP  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_EVICT = 2'd3
  } result_e;

  // strobes from control to datapath for the reference in the lookup stage
  typedef struct packed {
    logic touch;     // refresh stamp of the matching line
    logic fill;      // write tag into the chosen victim way
    logic hitOne;    // hit total +1
    logic hitTwo;    // hit total +2
    logic bumpMiss;  // miss total +1
    logic bumpEvict; // eviction total +1
  } ctrlStrobe_t;

endpackage

// File: rtl/cache_prof_satcnt.sv
module cache_prof_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             incOne,
  input  logic             incTwo,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0] step;
  logic [CNT_W:0] sum;

  always_comb begin
    if (incTwo)      step = (CNT_W+1)'(2);
    else if (incOne) step = (CNT_W+1)'(1);
    else             step = '0;
    sum = {1'b0, count} + step;
  end

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (sum[CNT_W]) count <= CNT_MAX;
    else               count <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/cache_prof_dp.sv
module cache_prof_dp
  import cache_prof_pkg::*;
#(
  parameter int SET_BITS = 2,
  parameter int OFF_BITS = 4,
  parameter int WAYS     = 2,
  parameter int CNT_W    = 32,
  parameter int STAMP_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [1:0]       inOp,
  input  logic [63:0]      inAddr,
  input  ctrlStrobe_t      strobe,
  output logic             reqValid,
  output logic [1:0]       reqOp,
  output logic             hitAny,
  output logic             emptyAny,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] evictCount
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = 64 - SET_BITS - OFF_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [SET_BITS-1:0] reqIdx;
  logic [TAG_W-1:0]    reqTag;
  logic [STAMP_W-1:0]  reqStamp;
  logic [STAMP_W-1:0]  refCount;
  logic                offsetUnused;

  assign offsetUnused = ^inAddr[OFF_BITS-1:0];

  // request register: first pipeline stage
  always_ff @(posedge clk) begin
    if (rst) begin
      reqValid <= 1'b0;
      reqOp    <= '0;
      reqIdx   <= '0;
      reqTag   <= '0;
      reqStamp <= '0;
      refCount <= '0;
    end else begin
      reqValid <= accept;
      if (accept) begin
        reqOp    <= inOp;
        reqIdx   <= inAddr[OFF_BITS +: SET_BITS];
        reqTag   <= inAddr[63 -: TAG_W];
        reqStamp <= refCount;
        refCount <= refCount + 1'b1;
      end
    end
  end

  // tag store
  logic               lineValid [SETS][WAYS];
  logic [TAG_W-1:0]   lineTag   [SETS][WAYS];
  logic [STAMP_W-1:0] lineStamp [SETS][WAYS];

  logic [WAYS-1:0] matchVec;
  logic [WAYS-1:0] freeVec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign matchVec[w] = lineValid[reqIdx][w] && (lineTag[reqIdx][w] == reqTag);
    assign freeVec[w]  = !lineValid[reqIdx][w];
  end

  assign hitAny   = |matchVec;
  assign emptyAny = |freeVec;

  logic [WAY_W-1:0]   hitWay;
  logic [WAY_W-1:0]   victimWay;
  logic               hitSeen;
  logic               freeSeen;
  logic [STAMP_W-1:0] bestStamp;

  always_comb begin
    hitWay  = '0;
    hitSeen = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hitSeen && matchVec[w]) begin
        hitWay  = WAY_W'(w);
        hitSeen = 1'b1;
      end
    end
  end

  // victim: lowest free way, else smallest stamp with ties to lowest way
  always_comb begin
    victimWay = '0;
    freeSeen  = 1'b0;
    bestStamp = lineStamp[reqIdx][0];
    for (int w = 0; w < WAYS; w++) begin
      if (!freeSeen && freeVec[w]) begin
        victimWay = WAY_W'(w);
        freeSeen  = 1'b1;
      end
    end
    if (!freeSeen) begin
      for (int w = 1; w < WAYS; w++) begin
        if (lineStamp[reqIdx][w] < bestStamp) begin
          bestStamp = lineStamp[reqIdx][w];
          victimWay = WAY_W'(w);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          lineValid[s][w] <= 1'b0;
          lineTag[s][w]   <= '0;
          lineStamp[s][w] <= '0;
        end
      end
    end else begin
      if (strobe.touch) lineStamp[reqIdx][hitWay] <= reqStamp;
      if (strobe.fill) begin
        lineValid[reqIdx][victimWay] <= 1'b1;
        lineTag[reqIdx][victimWay]   <= reqTag;
        lineStamp[reqIdx][victimWay] <= reqStamp;
      end
    end
  end

  cache_prof_satcnt #(.CNT_W(CNT_W)) u_hitCnt (
    .clk(clk), .rst(rst), .incOne(strobe.hitOne), .incTwo(strobe.hitTwo), .count(hitCount)
  );
  cache_prof_satcnt #(.CNT_W(CNT_W)) u_missCnt (
    .clk(clk), .rst(rst), .incOne(strobe.bumpMiss), .incTwo(1'b0), .count(missCount)
  );
  cache_prof_satcnt #(.CNT_W(CNT_W)) u_evictCnt (
    .clk(clk), .rst(rst), .incOne(strobe.bumpEvict), .incTwo(1'b0), .count(evictCount)
  );
endmodule

// File: rtl/cache_prof_ctrl.sv
module cache_prof_ctrl
  import cache_prof_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        hitAny,
  input  logic        emptyAny,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic [1:0]  outCode,
  output logic        outStoreHit
);
  result_e code;
  logic    isModify;
  logic    storeHit;

  assign isModify = (reqOp == OP_MODIFY);

  always_comb begin
    strobe   = '0;
    code     = RES_SKIP;
    storeHit = 1'b0;
    if (reqValid && reqOp != OP_FETCH) begin
      storeHit = isModify;
      if (hitAny) begin
        code         = RES_HIT;
        strobe.touch = 1'b1;
        if (isModify) strobe.hitTwo = 1'b1;
        else          strobe.hitOne = 1'b1;
      end else begin
        strobe.fill      = 1'b1;
        strobe.bumpMiss  = 1'b1;
        strobe.bumpEvict = !emptyAny;
        strobe.hitOne    = isModify;
        code             = emptyAny ? RES_MISS : RES_EVICT;
      end
    end
  end

  // result register: second pipeline stage
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      outCode     <= RES_SKIP;
      outStoreHit <= 1'b0;
    end else begin
      outValid    <= reqValid;
      outCode     <= code;
      outStoreHit <= storeHit;
    end
  end
endmodule

// File: rtl/cache_profiler.sv
module cache_profiler
  import cache_prof_pkg::*;
#(
  parameter int SET_BITS = 2,
  parameter int OFF_BITS = 4,
  parameter int WAYS     = 2,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inOp,
  input  logic [63:0]      inAddr,
  output logic             outValid,
  output logic [1:0]       outCode,
  output logic             outStoreHit,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] evictCount
);
  ctrlStrobe_t strobe;
  logic        accept;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic        hitAny;
  logic        emptyAny;

  assign inReady = !rst;
  assign accept  = inValid && inReady;

  cache_prof_dp #(
    .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS), .WAYS(WAYS), .CNT_W(CNT_W), .STAMP_W(32)
  ) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .inOp(inOp), .inAddr(inAddr),
    .strobe(strobe), .reqValid(reqValid), .reqOp(reqOp),
    .hitAny(hitAny), .emptyAny(emptyAny),
    .hitCount(hitCount), .missCount(missCount), .evictCount(evictCount)
  );

  cache_prof_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .hitAny(hitAny), .emptyAny(emptyAny), .strobe(strobe),
    .outValid(outValid), .outCode(outCode), .outStoreHit(outStoreHit)
  );
endmodule

// File: rtl/cache_prof_chk.sv
module cache_prof_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [1:0]       outCode,
  input logic             outStoreHit,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount,
  input logic [CNT_W-1:0] evictCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // R2
  a_r2_skip_frozen: assert property (@(posedge clk) disable iff (rst)
    (outValid && outCode == 2'd0) |->
      ($stable(hitCount) && $stable(missCount) && $stable(evictCount)));

  // R3
  a_r3_hit_step: assert property (@(posedge clk) disable iff (rst)
    (outValid && outCode == 2'd1 && !outStoreHit) |->
      ((hitCount == $past(hitCount) + CNT_ONE) || ($past(hitCount) == CNT_MAX))
      && $stable(missCount) && $stable(evictCount));

  // R4
  a_r4_miss_step: assert property (@(posedge clk) disable iff (rst)
    (outValid && outCode == 2'd2) |->
      ((missCount == $past(missCount) + CNT_ONE) || ($past(missCount) == CNT_MAX))
      && $stable(evictCount));

  // R5
  a_r5_evict_bounded: assert property (@(posedge clk) disable iff (rst)
    evictCount <= missCount);

  // R6
  a_r6_storehit_scope: assert property (@(posedge clk) disable iff (rst)
    outStoreHit |-> (outValid && outCode != 2'd0));

  // R7
  a_r7_result_latency: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && inReady, 2));

  // R9
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hitCount >= $past(hitCount) && missCount >= $past(missCount)
                    && evictCount >= $past(evictCount)));

  // R10
  a_r10_ready: assert property (@(posedge clk) !rst |-> inReady);
endmodule

bind cache_profiler cache_prof_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outCode(outCode), .outStoreHit(outStoreHit),
  .hitCount(hitCount), .missCount(missCount), .evictCount(evictCount)
);

// File: tb/cache_profiler_tb.sv
module cache_profiler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 2;
  localparam int OB = 4;
  localparam int WY = 2;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [1:0]    inOp = '0;
  logic [63:0]   inAddr = '0;
  logic          outValid;
  logic [1:0]    outCode;
  logic          outStoreHit;
  logic [CW-1:0] hitCount, missCount, evictCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_profiler #(.SET_BITS(SB), .OFF_BITS(OB), .WAYS(WY), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inOp(inOp),
    .inAddr(inAddr), .outValid(outValid), .outCode(outCode), .outStoreHit(outStoreHit),
    .hitCount(hitCount), .missCount(missCount), .evictCount(evictCount)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    code;
    bit    sh;
    int    h, m, e;
    int    issue;
    string req;
  } exp_t;
  exp_t q[$];

  // reference model
  bit              mV [4][2];
  longint unsigned mT [4][2];
  int unsigned     mS [4][2];
  int unsigned     mRef;
  int              eHit, eMiss, eEv;

  function automatic int sat(int v, int d);
    return (v + d > CMAX) ? CMAX : v + d;
  endfunction

  task automatic modelClear();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
        mV[s][w] = 0; mT[s][w] = 0; mS[s][w] = 0;
      end
    mRef = 0; eHit = 0; eMiss = 0; eEv = 0;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: called at a negedge, holds the reference for one cycle
  task automatic send(int op, longint unsigned addr, string req);
    exp_t it;
    int idx, hw, vw;
    longint unsigned tg;
    int unsigned st;
    idx = int'((addr >> OB) & 3);
    tg  = addr >> (OB + SB);
    st  = mRef; mRef++;
    it.sh = (op == 3);
    if (op == 0) it.code = 0;
    else begin
      hw = -1;
      for (int w = 0; w < WY; w++) if (hw < 0 && mV[idx][w] && mT[idx][w] == tg) hw = w;
      if (hw >= 0) begin
        it.code = 1; mS[idx][hw] = st;
        eHit = sat(eHit, (op == 3) ? 2 : 1);
      end else begin
        vw = -1;
        for (int w = 0; w < WY; w++) if (vw < 0 && !mV[idx][w]) vw = w;
        if (vw >= 0) it.code = 2;
        else begin
          it.code = 3; vw = 0;
          for (int w = 1; w < WY; w++) if (mS[idx][w] < mS[idx][vw]) vw = w;
          eEv = sat(eEv, 1);
        end
        mV[idx][vw] = 1; mT[idx][vw] = tg; mS[idx][vw] = st;
        eMiss = sat(eMiss, 1);
        if (op == 3) eHit = sat(eHit, 1);
      end
    end
    it.h = eHit; it.m = eMiss; it.e = eEv;
    it.issue = cyc; it.req = req;
    q.push_back(it);
    inValid = 1'b1; inOp = 2'(op); inAddr = addr;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (!rst && outValid) begin
        if (q.size() == 0) check(0, "R7", "unexpected result", 1, 0);
        else begin
          it = q.pop_front();
          check(outCode == 2'(it.code) && outStoreHit == it.sh &&
                int'(hitCount) == it.h && int'(missCount) == it.m &&
                int'(evictCount) == it.e, it.req, "code",
                int'(outCode) * 1000000 + int'(outStoreHit) * 100000 + int'(hitCount) * 1000
                  + int'(missCount) * 10 + int'(evictCount),
                it.code * 1000000 + int'(it.sh) * 100000 + it.h * 1000 + it.m * 10 + it.e);
          check(cyc - it.issue == 2, "R7", "latency", cyc - it.issue, 2);
        end
      end
    end
  end

  function automatic longint unsigned mk(longint unsigned tg, int idx, int off);
    return (tg << (OB + SB)) | (longint'(idx) << OB) | longint'(off);
  endfunction

  task automatic doReset();
    idle(3);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(inReady == 1'b0, "R10", "ready in reset", int'(inReady), 0);
    rst = 1'b0;
    modelClear();
    @(negedge clk);
    check(hitCount == 0 && missCount == 0 && evictCount == 0, "R8", "counters after reset",
          int'(hitCount) + int'(missCount) + int'(evictCount), 0);
    check(outValid == 1'b0, "R8", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R10", "ready after reset", int'(inReady), 1);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R7", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    modelClear();
    @(negedge clk);
    doReset();

    // R1, R3, R4: fill, offset independence, store hit
    send(1, mk(1, 0, 0), "R4");
    send(1, mk(1, 0, 5), "R1");
    send(2, mk(1, 0, 15), "R3");
    // R1: top tag bit distinguishes blocks
    send(1, mk(1, 0, 0) | 64'h8000_0000_0000_0000, "R1");
    idle(3);
    doReset();

    // R2: fetch leaves state alone; next load still misses into way 1
    send(1, mk(1, 0, 0), "R4");
    send(0, mk(9, 0, 0), "R2");
    send(1, mk(9, 0, 3), "R4");
    // R5: refresh tag1, then new tag evicts tag9 (LRU)
    send(1, mk(1, 0, 0), "R3");
    send(0, mk(1, 0, 0), "R2");
    send(1, mk(2, 0, 0), "R5");
    send(1, mk(1, 0, 0), "R5");
    send(1, mk(9, 0, 0), "R5");
    send(2, mk(1, 0, 8), "R3");
    // other sets independent
    send(2, mk(2, 1, 0), "R4");
    send(1, mk(2, 3, 0), "R4");
    // R6: modify miss, modify hit, modify evict
    send(3, mk(5, 2, 0), "R6");
    send(3, mk(5, 2, 4), "R6");
    send(3, mk(6, 2, 0), "R6");
    send(3, mk(7, 2, 0), "R6");
    idle(3);

    // R8: after reset a resident block misses again
    doReset();
    send(1, mk(2, 1, 0), "R8");
    idle(2);

    // pseudo-random mix across all opcodes
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'(lfsr[1:0]), mk(longint'(lfsr[4:2]), int'(lfsr[6:5]), int'(lfsr[10:7])),
           "R5");
      if (lfsr[11] && lfsr[12]) idle(1);
    end
    idle(3);

    // R9: saturation with single and double increments
    doReset();
    for (int i = 0; i < 70; i++) send(1, mk(3, 0, 0), "R9");
    send(3, mk(3, 0, 0), "R9");
    send(3, mk(4, 0, 0), "R9");
    idle(4);
    check(int'(hitCount) == CMAX, "R9", "hit total clamped", int'(hitCount), CMAX);
    check(q.size() == 0, "R7", "results outstanding", q.size(), 0);
    finishRun();
  end
endmodule